// File: doc/BRIEF.md
# Scoreboard Dynamic Instruction Scheduler

This block is the central scheduling controller for a floating-point pipeline that has several functional units, none of them pipelined. Decoded instructions arrive one at a time in program order. Each carries a unit class, a destination register and two source registers. The controller decides, cycle by cycle, when each instruction issues to a unit, reads its operands, finishes executing and writes its result back. It does this by keeping three pieces of state: a status entry per functional unit, a table that records which unit will produce each register, and a phase per unit.

Each unit entry holds the destination, both source register numbers, the producer tag of each source and a ready flag for each source. Three kinds of hazard are resolved through these entries:
- A structural hazard, or a pending writer of the destination (write-after-write), stalls issue.
- A pending producer of a source (read-after-write) holds the operand read.
- A reader that has not yet taken an older value of the destination (write-after-read) holds write-back.

Each unit contains a countdown model of its execution latency. The block reports operand-read (start), execution-complete and write-back events at its ports, so that a datapath can follow them.

Top module: `ooo_scoreboard`

## Requirements
- R1: Issue is strictly in program order. `ins_ready` is high only for the presented instruction. While that instruction stalls, no later one issues, even if its own unit is free. Class codes are memory=0, multiply=1, add/subtract=2, divide=3. Unit indices are 0 memory, 1 and 2 multiply, 3 add/subtract, 4 divide. An issue goes to the lowest-numbered free unit of the class.
- R2: An instruction issues only if a unit of its class is idle. A unit that writes back in cycle c can accept a new issue in cycle c+1.
- R3: An instruction whose destination register has a pending writer stalls. It issues in the cycle after that writer's write-back.
- R4: A unit raises its `fu_start` bit in the first cycle in which both of its sources are ready, and never in its issue cycle. A source written back in cycle c is ready in cycle c+1. Once the operands are read, both ready flags are cleared.
- R5: `fu_done` rises exactly LAT cycles after `fu_start`. LAT is 1 for memory, 2 for add/subtract, 10 for multiply and 40 for divide.
- R6: Write-back happens no earlier than the cycle after `fu_done`. It frees the unit and clears the register's producer entry. Every waiting source that names the unit becomes ready.
- R7: Write-back is held while another busy unit has a source equal to this unit's destination, with that source's ready flag set and the operand not yet read. It proceeds in the cycle after that read.
- R8: At most one write-back happens per cycle. When several units are eligible, the lowest unit index writes first.
- R9: When an instruction issues in the same cycle as the write-back of its source's producer, that source is treated as ready at issue. The operand read follows in the next cycle.
- R10: After reset no unit is busy, and `fu_start`, `fu_done`, `wb_valid` and `ins_ready` are low while no instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_valid | input | 1 | An instruction is presented |
| ins_class | input | 2 | Unit class of the instruction (R1 encoding) |
| ins_dst | input | 5 | Destination register |
| ins_src_j | input | 5 | First source register |
| ins_src_k | input | 5 | Second source register |
| ins_ready | output | 1 | The presented instruction issues this cycle |
| iss_unit | output | 3 | Unit index chosen for the issue |
| fu_start | output | 5 | Per unit: operands read, execution starts |
| fu_done | output | 5 | Per unit: execution complete |
| wb_valid | output | 1 | A unit writes back this cycle |
| wb_unit | output | 3 | Index of the writing unit |
| wb_reg | output | 5 | Register being written |

## Verification
The hardest situation to reach from the ports is two finished units that are both held by write-after-read and are released in the same cycle, which is the only way to exercise the write-back priority. The stimulus first issues a long multiply, then two readers that each wait on it with one source ready. It then issues a load and an add that overwrite those ready sources, so both stay held until the multiply's result lets the readers consume their operands together. A second hard case is an issue landing exactly in the write-back cycle of its source's producer. The bench withholds that instruction until the known write-back cycle and presents it then. If the source were not treated as ready at issue, the operand read would never happen.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } fu_class_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RESULT = 2'd3
  } fu_phase_e;

  // Units are laid out by class: memory, multiply, add/subtract, divide.
  function automatic fu_class_e class_of(int idx, int n_mem, int n_mul, int n_add);
    if (idx < n_mem)                     return CLS_MEM;
    else if (idx < n_mem + n_mul)        return CLS_MUL;
    else if (idx < n_mem + n_mul + n_add) return CLS_ADD;
    else                                 return CLS_DIV;
  endfunction

  function automatic int lat_of(fu_class_e c, int l_mem, int l_mul, int l_add, int l_div);
    case (c)
      CLS_MEM: return l_mem;
      CLS_MUL: return l_mul;
      CLS_ADD: return l_add;
      default: return l_div;
    endcase
  endfunction

endpackage

// File: rtl/sb_fu_slot.sv
module sb_fu_slot #(
  parameter int RW  = 5,
  parameter int TW  = 3,
  parameter int CW  = 6,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_en,
  input  logic [RW-1:0] iss_fi,
  input  logic [RW-1:0] iss_fj,
  input  logic [RW-1:0] iss_fk,
  input  logic [TW-1:0] iss_qj,
  input  logic [TW-1:0] iss_qk,
  input  logic          wb_en,
  input  logic [TW-1:0] wb_tag,
  input  logic          grant,
  output logic          busy,
  output logic          rd_fire,
  output logic          done_fire,
  output logic          result_rdy,
  output logic [RW-1:0] fi,
  output logic [RW-1:0] fj,
  output logic [RW-1:0] fk,
  output logic          rj,
  output logic          rk
);
  import sb_pkg::*;

  fu_phase_e     phase_q, phase_d;
  logic [RW-1:0] fi_q, fj_q, fk_q;
  logic [TW-1:0] qj_q, qj_d, qk_q, qk_d;
  logic          rj_q, rj_d, rk_q, rk_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fld_en, tag_en, cnt_en;

  assign fld_en = (phase_q == PH_IDLE) && issue_en;
  assign tag_en = fld_en || (phase_q == PH_WAIT);
  assign cnt_en = rd_fire || (phase_q == PH_EXEC);

  always_comb begin
    phase_d   = phase_q;
    qj_d      = qj_q;
    qk_d      = qk_q;
    rj_d      = rj_q;
    rk_d      = rk_q;
    cnt_d     = cnt_q;
    rd_fire   = 1'b0;
    done_fire = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (issue_en) begin
          phase_d = PH_WAIT;
          qj_d    = iss_qj;
          qk_d    = iss_qk;
          rj_d    = (iss_qj == '0);
          rk_d    = (iss_qk == '0);
        end
      end
      PH_WAIT: begin
        if (wb_en && (qj_q != '0) && (qj_q == wb_tag)) begin
          qj_d = '0;
          rj_d = 1'b1;
        end
        if (wb_en && (qk_q != '0) && (qk_q == wb_tag)) begin
          qk_d = '0;
          rk_d = 1'b1;
        end
        if (rj_q && rk_q) begin
          rd_fire = 1'b1;
          phase_d = PH_EXEC;
          cnt_d   = CW'(LAT);
          rj_d    = 1'b0;
          rk_d    = 1'b0;
        end
      end
      PH_EXEC: begin
        if (cnt_q == CW'(1)) begin
          done_fire = 1'b1;
          phase_d   = PH_RESULT;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        if (grant) phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_q <= '0;
      fj_q <= '0;
      fk_q <= '0;
    end else if (fld_en) begin
      fi_q <= iss_fi;
      fj_q <= iss_fj;
      fk_q <= iss_fk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qj_q <= '0;
      qk_q <= '0;
      rj_q <= 1'b0;
      rk_q <= 1'b0;
    end else if (tag_en) begin
      qj_q <= qj_d;
      qk_q <= qk_d;
      rj_q <= rj_d;
      rk_q <= rk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign result_rdy = (phase_q == PH_RESULT);
  assign fi         = fi_q;
  assign fj         = fj_q;
  assign fk         = fk_q;
  assign rj         = rj_q;
  assign rk         = rk_q;

  // Independent count of the cycles spent executing, for the latency check.
  logic [CW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (rd_fire) begin
      age_q <= CW'(1);
    end else if (phase_q == PH_EXEC) begin
      age_q <= age_q + CW'(1);
    end
  end

  // R2
  issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !busy);

  // R4
  ops_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (!rj && !rk && busy));

  // R5
  exec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |-> (age_q == CW'(LAT)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_rdy && !grant) |=> result_rdy);

endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int RW = 5,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [RW-1:0] set_reg,
  input  logic [TW-1:0] set_tag,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_reg,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic [RW-1:0] rd_c,
  output logic [TW-1:0] tag_a,
  output logic [TW-1:0] tag_b,
  output logic [TW-1:0] tag_c
);
  localparam int NREG = 2 ** RW;

  logic [NREG-1:0][TW-1:0] tag_q;

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic          hit_set, hit_clr, en;
    logic [TW-1:0] nxt;
    assign hit_set = set_en && (set_reg == RW'(r));
    assign hit_clr = clr_en && (clr_reg == RW'(r));
    assign en      = hit_set || hit_clr;
    always_comb begin
      nxt = '0;
      if (hit_set) nxt = set_tag;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[r] <= '0;
      end else if (en) begin
        tag_q[r] <= nxt;
      end
    end
  end

  assign tag_a = tag_q[rd_a];
  assign tag_b = tag_q[rd_b];
  assign tag_c = tag_q[rd_c];

  // R3
  no_waw_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (tag_q[set_reg] == '0));

  // R6
  clear_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (tag_q[clr_reg] != '0));

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NFU = 5,
  parameter int RW  = 5,
  parameter int UW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NFU-1:0]          busy,
  input  logic [NFU-1:0]          result_rdy,
  input  logic [NFU-1:0][RW-1:0]  fi,
  input  logic [NFU-1:0][RW-1:0]  fj,
  input  logic [NFU-1:0][RW-1:0]  fk,
  input  logic [NFU-1:0]          rj,
  input  logic [NFU-1:0]          rk,
  output logic [NFU-1:0]          grant,
  output logic                    wb_valid,
  output logic [UW-1:0]           wb_idx
);
  logic [NFU-1:0] war_hold;
  logic [NFU-1:0] eligible;

  // A finished unit is held while another unit still owes a read of the old value.
  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war_hold[u] = 1'b0;
      for (int v = 0; v < NFU; v++) begin
        if ((v != u) && busy[v] &&
            ((rj[v] && (fj[v] == fi[u])) || (rk[v] && (fk[v] == fi[u]))))
          war_hold[u] = 1'b1;
      end
    end
  end

  assign eligible = result_rdy & ~war_hold;

  always_comb begin
    grant    = '0;
    wb_valid = 1'b0;
    wb_idx   = '0;
    for (int u = 0; u < NFU; u++) begin
      if (eligible[u] && !wb_valid) begin
        wb_valid = 1'b1;
        wb_idx   = UW'(u);
        grant[u] = 1'b1;
      end
    end
  end

  // R8
  single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  grant_finished_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~result_rdy) == '0));

endmodule

// File: rtl/ooo_scoreboard.sv
module ooo_scoreboard #(
  parameter int RW      = 5,
  parameter int N_MEM   = 1,
  parameter int N_MUL   = 2,
  parameter int N_ADD   = 1,
  parameter int N_DIV   = 1,
  parameter int LAT_MEM = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40,
  localparam int NFU    = N_MEM + N_MUL + N_ADD + N_DIV,
  localparam int UW     = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ins_valid,
  input  logic [1:0]     ins_class,
  input  logic [RW-1:0]  ins_dst,
  input  logic [RW-1:0]  ins_src_j,
  input  logic [RW-1:0]  ins_src_k,
  output logic           ins_ready,
  output logic [UW-1:0]  iss_unit,
  output logic [NFU-1:0] fu_start,
  output logic [NFU-1:0] fu_done,
  output logic           wb_valid,
  output logic [UW-1:0]  wb_unit,
  output logic [RW-1:0]  wb_reg
);
  import sb_pkg::*;

  localparam int TW      = $clog2(NFU + 1);
  localparam int LAT_A   = (LAT_MEM > LAT_MUL) ? LAT_MEM : LAT_MUL;
  localparam int LAT_B   = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int CW      = $clog2(LAT_MAX + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NFU-1:0][1:0]    unit_cls;
  logic [NFU-1:0]         slot_busy, slot_rdy, slot_grant, slot_issue;
  logic [NFU-1:0][RW-1:0] slot_fi, slot_fj, slot_fk;
  logic [NFU-1:0]         slot_rj, slot_rk;
  logic [TW-1:0]          tag_dst, tag_j, tag_k, qj_iss, qk_iss, wb_tag;
  logic [UW-1:0]          pick_idx, wb_idx;
  logic                   pick_found, waw_stall, issue_go, wb_go;

  // Issue: lowest idle unit of the requested class, no pending writer of the destination.
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int i = 0; i < NFU; i++) begin
      if (!pick_found && (unit_cls[i] == ins_class) && !slot_busy[i]) begin
        pick_found = 1'b1;
        pick_idx   = UW'(i);
      end
    end
  end

  assign waw_stall = (tag_dst != '0);
  assign issue_go  = ins_valid && pick_found && !waw_stall;
  assign wb_tag    = TW'(wb_idx) + TW'(1);

  // The write-back of this cycle is seen first by an issuing instruction.
  assign qj_iss = (wb_go && (tag_j == wb_tag)) ? '0 : tag_j;
  assign qk_iss = (wb_go && (tag_k == wb_tag)) ? '0 : tag_k;

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    localparam fu_class_e SLOT_CLS = class_of(g, N_MEM, N_MUL, N_ADD);
    localparam int SLOT_LAT = lat_of(SLOT_CLS, LAT_MEM, LAT_MUL, LAT_ADD, LAT_DIV);

    assign unit_cls[g]   = SLOT_CLS;
    assign slot_issue[g] = issue_go && (pick_idx == UW'(g));

    sb_fu_slot #(
      .RW(RW), .TW(TW), .CW(CW), .LAT(SLOT_LAT)
    ) i_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .issue_en  (slot_issue[g]),
      .iss_fi    (ins_dst),
      .iss_fj    (ins_src_j),
      .iss_fk    (ins_src_k),
      .iss_qj    (qj_iss),
      .iss_qk    (qk_iss),
      .wb_en     (wb_go),
      .wb_tag    (wb_tag),
      .grant     (slot_grant[g]),
      .busy      (slot_busy[g]),
      .rd_fire   (fu_start[g]),
      .done_fire (fu_done[g]),
      .result_rdy(slot_rdy[g]),
      .fi        (slot_fi[g]),
      .fj        (slot_fj[g]),
      .fk        (slot_fk[g]),
      .rj        (slot_rj[g]),
      .rk        (slot_rk[g])
    );
  end

  sb_wb_arb #(.NFU(NFU), .RW(RW), .UW(UW)) i_arb (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .busy      (slot_busy),
    .result_rdy(slot_rdy),
    .fi        (slot_fi),
    .fj        (slot_fj),
    .fk        (slot_fk),
    .rj        (slot_rj),
    .rk        (slot_rk),
    .grant     (slot_grant),
    .wb_valid  (wb_go),
    .wb_idx    (wb_idx)
  );

  sb_regstat #(.RW(RW), .TW(TW)) i_regstat (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set_en (issue_go),
    .set_reg(ins_dst),
    .set_tag(TW'(pick_idx) + TW'(1)),
    .clr_en (wb_go),
    .clr_reg(wb_reg),
    .rd_a   (ins_dst),
    .rd_b   (ins_src_j),
    .rd_c   (ins_src_k),
    .tag_a  (tag_dst),
    .tag_b  (tag_j),
    .tag_c  (tag_k)
  );

  assign ins_ready = issue_go;
  assign iss_unit  = pick_idx;
  assign wb_valid  = wb_go;
  assign wb_unit   = wb_idx;
  assign wb_reg    = slot_fi[wb_idx];

  // R1
  issue_claims_unit_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ins_ready |=> slot_busy[$past(iss_unit)]);

  // R6
  wb_frees_unit_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wb_valid |=> !slot_busy[$past(wb_unit)]);

  // R4
  no_start_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ins_ready |-> !fu_start[iss_unit]);

endmodule

// File: tb/test_ooo_scoreboard.sv
module test_ooo_scoreboard;
  localparam int NFU = 5;
  localparam int MAXI = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ins_valid;
  logic [1:0]     ins_class;
  logic [4:0]     ins_dst, ins_src_j, ins_src_k;
  logic           ins_ready;
  logic [2:0]     iss_unit;
  logic [NFU-1:0] fu_start, fu_done;
  logic           wb_valid;
  logic [2:0]     wb_unit;
  logic [4:0]     wb_reg;

  always #4 clk = ~clk;

  ooo_scoreboard i_ooo_scoreboard (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
    .ins_dst(ins_dst), .ins_src_j(ins_src_j), .ins_src_k(ins_src_k),
    .ins_ready(ins_ready), .iss_unit(iss_unit), .fu_start(fu_start),
    .fu_done(fu_done), .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg)
  );

  int checks = 0;
  int errors = 0;

  int n_ins;
  int p_cls[MAXI], p_dst[MAXI], p_sj[MAXI], p_sk[MAXI], p_av[MAXI];
  int e_iss[MAXI], e_rd[MAXI], e_dn[MAXI], e_wb[MAXI];
  string t_iss[MAXI], t_wb[MAXI];
  int g_iss[MAXI], g_rd[MAXI], g_dn[MAXI], g_wb[MAXI], g_reg[MAXI];
  int unit_of[NFU];

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_ins(input int c, input int d, input int j, input int k, input int av,
                         input int ei, input int er, input int ed, input int ew,
                         input string ti, input string tw);
    p_cls[n_ins] = c; p_dst[n_ins] = d; p_sj[n_ins] = j; p_sk[n_ins] = k; p_av[n_ins] = av;
    e_iss[n_ins] = ei; e_rd[n_ins] = er; e_dn[n_ins] = ed; e_wb[n_ins] = ew;
    t_iss[n_ins] = ti; t_wb[n_ins] = tw;
    n_ins++;
  endtask

  // Cycle 1 is the first cycle in which the program may present an instruction.
  task automatic run_prog(input string name);
    int idx = 0;
    int cyc = 1;
    int wbs = 0;
    for (int i = 0; i < MAXI; i++) begin
      g_iss[i] = -1; g_rd[i] = -1; g_dn[i] = -1; g_wb[i] = -1; g_reg[i] = -1;
    end
    for (int u = 0; u < NFU; u++) unit_of[u] = -1;
    while ((wbs < n_ins) && (cyc <= 150)) begin
      @(negedge clk);
      if ((idx < n_ins) && (cyc >= p_av[idx])) begin
        ins_valid = 1'b1;
        ins_class = 2'(p_cls[idx]);
        ins_dst   = 5'(p_dst[idx]);
        ins_src_j = 5'(p_sj[idx]);
        ins_src_k = 5'(p_sk[idx]);
      end else begin
        ins_valid = 1'b0;
      end
      #1;
      for (int u = 0; u < NFU; u++) begin
        if (unit_of[u] >= 0) begin
          if (fu_start[u]) g_rd[unit_of[u]] = cyc;
          if (fu_done[u])  g_dn[unit_of[u]] = cyc;
        end
      end
      if (wb_valid) begin
        if (unit_of[int'(wb_unit)] >= 0) begin
          g_wb[unit_of[int'(wb_unit)]]  = cyc;
          g_reg[unit_of[int'(wb_unit)]] = int'(wb_reg);
        end
        wbs++;
      end
      if (ins_ready) begin
        if (idx < n_ins) begin
          g_iss[idx] = cyc;
          unit_of[int'(iss_unit)] = idx;
        end
        idx++;
      end
      cyc++;
    end
    @(negedge clk);
    ins_valid = 1'b0;
    for (int i = 0; i < n_ins; i++) begin
      check_eq(t_iss[i], $sformatf("%s ins%0d issue cycle", name, i), g_iss[i], e_iss[i]);
      check_eq("R4", $sformatf("%s ins%0d read cycle", name, i), g_rd[i], e_rd[i]);
      check_eq("R5", $sformatf("%s ins%0d done cycle", name, i), g_dn[i], e_dn[i]);
      check_eq(t_wb[i], $sformatf("%s ins%0d write cycle", name, i), g_wb[i], e_wb[i]);
      check_eq("R6", $sformatf("%s ins%0d written reg", name, i), g_reg[i], p_dst[i]);
    end
  endtask

  // R10: quiet outputs after reset with nothing presented.
  task automatic scen_reset();
    ins_valid = 1'b0;
    @(negedge clk);
    #1;
    check_eq("R10", "ins_ready after reset", int'(ins_ready), 0);
    check_eq("R10", "fu_start after reset", int'(fu_start), 0);
    check_eq("R10", "fu_done after reset", int'(fu_done), 0);
    check_eq("R10", "wb_valid after reset", int'(wb_valid), 0);
  endtask

  // Classic six-instruction sequence: loads, MUL, SUB, DIV, ADD (class 0 mem,1 mul,2 add,3 div).
  task automatic scen_classic();
    n_ins = 0;
    add_ins(0,  6, 30, 30, 1,  1,  2,  3,  4, "R1", "R6");
    add_ins(0,  2, 31, 31, 1,  5,  6,  7,  8, "R2", "R6");
    add_ins(1,  0,  2,  4, 1,  6,  9, 19, 20, "R1", "R6");
    add_ins(2,  8,  6,  2, 1,  7,  9, 11, 12, "R1", "R6");
    add_ins(3, 10,  0,  6, 1,  8, 21, 61, 62, "R1", "R6");
    add_ins(2,  6,  8,  2, 1, 13, 14, 16, 22, "R2", "R7");
    run_prog("classic");
  endtask

  // Same-cycle bypass at issue, WAW stall and in-order blocking.
  task automatic scen_bypass_waw();
    n_ins = 0;
    add_ins(2, 1, 0, 0, 1,  1,  2,  4,  5, "R1", "R6");
    add_ins(1, 3, 1, 0, 5,  5,  6, 16, 17, "R9", "R6");
    add_ins(1, 3, 0, 0, 6, 18, 19, 29, 30, "R3", "R6");
    add_ins(0, 9, 0, 0, 6, 19, 20, 21, 22, "R1", "R6");
    run_prog("bypass_waw");
  endtask

  // Two writers held by WAR and released together: lower unit index first.
  task automatic scen_tie_war();
    n_ins = 0;
    add_ins(1, 1, 2, 3, 1, 1,  2, 12, 13, "R1", "R6");
    add_ins(3, 4, 5, 1, 1, 2, 14, 54, 55, "R1", "R6");
    add_ins(1, 6, 7, 1, 1, 3, 14, 24, 25, "R1", "R6");
    add_ins(0, 5, 0, 0, 1, 4,  5,  6, 15, "R1", "R8");
    add_ins(2, 7, 0, 0, 1, 5,  6,  8, 16, "R1", "R8");
    run_prog("tie_war");
  endtask

  initial begin
    rst_n     = 1'b0;
    ins_valid = 1'b0;
    ins_class = '0;
    ins_dst   = '0;
    ins_src_j = '0;
    ins_src_k = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    scen_reset();
    scen_classic();
    scen_bypass_waw();
    scen_tie_war();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule